// File: doc/BRIEF.md
# Interrupt Routing Controller

The block gathers interrupt requests from many sources and steers them onto three processor request lines: critical, system management and standard. It takes four external request pins with selectable sensitivity, a set of peripheral request lines, two slice-timer ticks, eight general timers, two real-time clock events, eight wake-up pins and eight simple GPIO interrupts.

The peripheral lines are folded into two group requests, HI and LO. The DMA request, peripheral line 0, always lands in HI. The eight wake-up pins are merged into a single source.

Software drives a small register port. Through it, software sets the per-source masks, the external pin sensitivity, the per-group routing and the peripheral HI/LO assignment. It also clears latched edges and reads the raw status and the winning vector.

A low-power input limits the sources that may raise a request while the core naps. A watchdog input does not produce an interrupt. It produces a soft-reset indication.

Top module: `irq_router`

## Requirements
- R1: After reset all sources are masked (mask register address 1 reads 0x7FFFFFF), every external pin is level sensitive, all routing fields are 0, all three request outputs are low and `vec_o` reads 31.
- R2: An external pin whose sense bit (register address 2, bit i for pin i) is 0 shows directly in status bit i. Writing 1 to that bit at address 0 leaves it set while the pin stays high.
- R3: An external pin whose sense bit is 1 sets status bit i on the clock edge after a rising edge of the pin. The bit stays set until software writes 1 to it at address 0. A pin held high gives no new set after a clear.
- R4: A source whose mask bit is 1 still shows in `status_o` but drives no request output and is not reported in `vec_o`.
- R5: A peripheral line i with bit i of register address 4 set raises status bit 4 (HI). With that bit clear it raises status bit 5 (LO).
- R6: Peripheral line 0 (DMA) always raises status bit 4, whatever register address 4 holds.
- R7: Status bit 18 is the OR of the eight wake-up pins.
- R8: While `lowpwr_i` is high, only general timers 6 and 7 (status bits 14 and 15) and the wake-up group (bit 18) reach the request outputs and `vec_o`. All other sources, GPIO included, are ignored there but still show in `status_o`.
- R9: Register address 3 holds a 2-bit route field per group at bits [2g+1:2g]. The groups are external g=0, peripheral g=1, slice timer g=2, general timer g=3, real-time clock g=4, wake-up g=5 and GPIO g=6. Value 2 selects critical, 1 selects system management, and 0 or 3 select standard.
- R10: `vec_o` and register address 5 give the lowest status index among the unmasked qualified pending sources. When none is pending they read all ones: 31 on the port and 0xFFFFFFFF in the register.
- R11: `srst_o` rises one clock after `wdt_i` is sampled high. The watchdog never appears in the status bits or in the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_i | input | 4 | External request pins (status bits 0-3) |
| per_i | input | 19 | Peripheral request lines, line 0 is DMA |
| slt_i | input | 2 | Slice-timer ticks (bits 6-7) |
| gpt_i | input | 8 | General timer requests (bits 8-15) |
| rtc_i | input | 2 | Real-time clock stopwatch and periodic (bits 16-17) |
| wake_i | input | 8 | Wake-up pins, merged into bit 18 |
| gpio_i | input | 8 | Simple GPIO requests (bits 19-26) |
| lowpwr_i | input | 1 | Nap/doze/power-down qualifier |
| wdt_i | input | 1 | Watchdog expiry |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_crit_o | output | 1 | Critical request to core |
| irq_smi_o | output | 1 | System management request to core |
| irq_std_o | output | 1 | Standard request to core |
| status_o | output | 27 | Raw status of all sources |
| vec_o | output | 5 | Winning source index, 31 if none |
| srst_o | output | 1 | Soft-reset indication |

## Verification
The bench builds the block with its default counts: four external pins, nineteen peripheral lines, eight general timers and eight each of wake-up and GPIO pins. With these counts the full 27-bit status map is exercised. The DMA override on peripheral line 0 is driven against a cleared HI register. The low-power qualifier is tested at the exact indices of timers 6 and 7 next to a blocked timer 2. The vector tie-break is exercised across groups that sit far apart in the index space.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_EXT  = 4,
  parameter int N_PER  = 19,
  parameter int N_SLT  = 2,
  parameter int N_GPT  = 8,
  parameter int N_RTC  = 2,
  parameter int N_WK   = 8,
  parameter int N_GPIO = 8,
  parameter int WG_A   = 6,
  parameter int WG_B   = 7,
  parameter int AW     = 3,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_i,
  input  logic [N_PER-1:0]  per_i,
  input  logic [N_SLT-1:0]  slt_i,
  input  logic [N_GPT-1:0]  gpt_i,
  input  logic [N_RTC-1:0]  rtc_i,
  input  logic [N_WK-1:0]   wake_i,
  input  logic [N_GPIO-1:0] gpio_i,
  input  logic              lowpwr_i,
  input  logic              wdt_i,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_crit_o,
  output logic              irq_smi_o,
  output logic              irq_std_o,
  output logic [N_EXT+N_SLT+N_GPT+N_RTC+N_GPIO+2:0] status_o,
  output logic [$clog2(N_EXT+N_SLT+N_GPT+N_RTC+N_GPIO+4)-1:0] vec_o,
  output logic              srst_o
);
  localparam int O_EXT  = 0;
  localparam int O_HI   = N_EXT;
  localparam int O_LO   = O_HI + 1;
  localparam int O_SLT  = O_LO + 1;
  localparam int O_GPT  = O_SLT + N_SLT;
  localparam int O_RTC  = O_GPT + N_GPT;
  localparam int O_WK   = O_RTC + N_RTC;
  localparam int O_GPIO = O_WK + 1;
  localparam int NSRC   = O_GPIO + N_GPIO;
  localparam int VW     = $clog2(NSRC + 1);
  localparam int NGRP   = 7;

  localparam logic [AW-1:0] A_RAW   = 0;
  localparam logic [AW-1:0] A_MASK  = 1;
  localparam logic [AW-1:0] A_SENSE = 2;
  localparam logic [AW-1:0] A_ROUTE = 3;
  localparam logic [AW-1:0] A_PERHI = 4;
  localparam logic [AW-1:0] A_VEC   = 5;

  localparam logic [NSRC-1:0] ONE    = 1;
  localparam logic [NSRC-1:0] NAP_OK = (ONE << (O_GPT + WG_A)) | (ONE << (O_GPT + WG_B)) | (ONE << O_WK);

  logic [NSRC-1:0]    mask_q;
  logic [N_EXT-1:0]   sense_q, ext_d_q, edge_q;
  logic [2*NGRP-1:0]  route_q;
  logic [N_PER-1:0]   perhi_q;
  logic               srst_q;

  logic [N_EXT-1:0] clr_v, rise, edge_n, ext_eff;
  logic [N_PER-1:0] hi_sel;
  logic             per_hi, per_lo;
  logic [NSRC-1:0]  raw, act;
  logic [NGRP-1:0]  grp;
  logic [VW-1:0]    vec;

  assign clr_v   = (reg_we && reg_addr == A_RAW) ? reg_wdata[N_EXT-1:0] : '0;
  assign rise    = ext_i & ~ext_d_q;
  assign edge_n  = sense_q & (rise | (edge_q & ~clr_v));
  assign ext_eff = (sense_q & edge_q) | (~sense_q & ext_i);

  assign hi_sel = perhi_q | {{(N_PER-1){1'b0}}, 1'b1};
  assign per_hi = |(per_i & hi_sel);
  assign per_lo = |(per_i & ~hi_sel);

  assign raw = {gpio_i, |wake_i, rtc_i, gpt_i, slt_i, per_lo, per_hi, ext_eff};
  assign act = raw & ~mask_q & (lowpwr_i ? NAP_OK : {NSRC{1'b1}});

  assign grp[0] = |act[O_EXT  +: N_EXT];
  assign grp[1] = |act[O_HI   +: 2];
  assign grp[2] = |act[O_SLT  +: N_SLT];
  assign grp[3] = |act[O_GPT  +: N_GPT];
  assign grp[4] = |act[O_RTC  +: N_RTC];
  assign grp[5] = act[O_WK];
  assign grp[6] = |act[O_GPIO +: N_GPIO];

  always_comb begin
    vec = '1;
    for (int i = NSRC - 1; i >= 0; i--)
      if (act[i]) vec = VW'(i);
  end

  always_comb begin
    irq_crit_o = 1'b0;
    irq_smi_o  = 1'b0;
    irq_std_o  = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp[g]) begin
        case (route_q[2*g +: 2])
          2'd2:    irq_crit_o = 1'b1;
          2'd1:    irq_smi_o  = 1'b1;
          default: irq_std_o  = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_RAW:   reg_rdata = DW'(raw);
      A_MASK:  reg_rdata = DW'(mask_q);
      A_SENSE: reg_rdata = DW'(sense_q);
      A_ROUTE: reg_rdata = DW'(route_q);
      A_PERHI: reg_rdata = DW'(perhi_q);
      A_VEC:   reg_rdata = (act == '0) ? '1 : DW'(vec);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '1;
      sense_q <= '0;
      route_q <= '0;
      perhi_q <= '0;
      ext_d_q <= '0;
      edge_q  <= '0;
      srst_q  <= 1'b0;
    end else begin
      ext_d_q <= ext_i;
      edge_q  <= edge_n;
      srst_q  <= wdt_i;
      if (reg_we) begin
        case (reg_addr)
          A_MASK:  mask_q  <= reg_wdata[NSRC-1:0];
          A_SENSE: sense_q <= reg_wdata[N_EXT-1:0];
          A_ROUTE: route_q <= reg_wdata[2*NGRP-1:0];
          A_PERHI: perhi_q <= reg_wdata[N_PER-1:0];
          default: ;
        endcase
      end
    end
  end

  assign status_o = raw;
  assign vec_o    = vec;
  assign srst_o   = srst_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_EXT = 4,
  parameter int N_PER = 19,
  parameter int N_WK  = 8,
  parameter int NSRC  = 27,
  parameter int VW    = 5,
  parameter int AW    = 3,
  parameter int DW    = 32,
  parameter int I_HI  = 4,
  parameter int I_WK  = 18,
  parameter int I_GA  = 14,
  parameter int I_GB  = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_PER-1:0] per_i,
  input logic [N_WK-1:0]  wake_i,
  input logic             lowpwr_i,
  input logic             wdt_i,
  input logic             reg_we,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [N_EXT-1:0] sense_q,
  input logic [N_EXT-1:0] edge_q,
  input logic             irq_crit_o,
  input logic             irq_smi_o,
  input logic             irq_std_o,
  input logic [NSRC-1:0]  status_o,
  input logic [VW-1:0]    vec_o,
  input logic             srst_o
);
  logic any_irq;
  assign any_irq = irq_crit_o | irq_smi_o | irq_std_o;

  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !any_irq |-> vec_o == {VW{1'b1}}); // R10

  AST_DMA_HI: assert property (@(posedge clk) disable iff (!rst_n)
    per_i[0] |-> status_o[I_HI]); // R6

  AST_WAKE_OR: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[I_WK] == (|wake_i)); // R7

  AST_NAP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (lowpwr_i && !status_o[I_GA] && !status_o[I_GB] && !status_o[I_WK]) |-> !any_irq); // R8

  AST_SRST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_i |=> srst_o); // R11

  for (genvar i = 0; i < N_EXT; i++) begin : g_edge
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q[i] && edge_q[i] && !(reg_we && reg_addr == AW'(0) && reg_wdata[i])
       && !(reg_we && reg_addr == AW'(2))) |=> edge_q[i]); // R3
  end
endmodule

bind irq_router irq_router_chk #(
  .N_EXT(N_EXT), .N_PER(N_PER), .N_WK(N_WK), .NSRC(NSRC), .VW(VW), .AW(AW), .DW(DW),
  .I_HI(O_HI), .I_WK(O_WK), .I_GA(O_GPT + WG_A), .I_GB(O_GPT + WG_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .per_i(per_i), .wake_i(wake_i), .lowpwr_i(lowpwr_i),
  .wdt_i(wdt_i), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .sense_q(sense_q), .edge_q(edge_q), .irq_crit_o(irq_crit_o), .irq_smi_o(irq_smi_o),
  .irq_std_o(irq_std_o), .status_o(status_o), .vec_o(vec_o), .srst_o(srst_o)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  ext_i = 0;
  logic [18:0] per_i = 0;
  logic [1:0]  slt_i = 0, rtc_i = 0;
  logic [7:0]  gpt_i = 0, wake_i = 0, gpio_i = 0;
  logic        lowpwr_i = 0, wdt_i = 0, reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq_crit_o, irq_smi_o, irq_std_o, srst_o;
  logic [26:0] status_o;
  logic [4:0]  vec_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_router uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0; reg_addr = 0;
    #1;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic settle(); @(negedge clk); #1; endtask

  task automatic quiet();
    @(negedge clk);
    ext_i = 0; per_i = 0; slt_i = 0; rtc_i = 0; gpt_i = 0; wake_i = 0; gpio_i = 0;
    lowpwr_i = 0; wdt_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd1, d); chk("R1 mask", d, 32'h07FF_FFFF);
    rd(3'd2, d); chk("R1 sense", d, 0);
    rd(3'd3, d); chk("R1 route", d, 0);
    chk("R1 irqs", {irq_crit_o, irq_smi_o, irq_std_o}, 0);
    chk("R1 vec", vec_o, 31);
    @(negedge clk); ext_i = 4'h1; settle();
    chk("R1 masked ext no irq", irq_std_o, 0);
    quiet();
  endtask

  task automatic t_level();
    wr(3'd1, 0);
    @(negedge clk); ext_i[1] = 1; #1;
    chk("R2 level status", status_o[1], 1);
    chk("R2 vec", vec_o, 1);
    chk("R2 std", irq_std_o, 1);
    wr(3'd0, 32'h2);
    chk("R2 w1c no effect", status_o[1], 1);
    @(negedge clk); ext_i[1] = 0; #1;
    chk("R2 follows pin low", status_o[1], 0);
  endtask

  task automatic t_edge();
    wr(3'd2, 32'h4);
    @(negedge clk); ext_i[2] = 1;
    @(negedge clk); ext_i[2] = 0; #1;
    chk("R3 latched", status_o[2], 1);
    settle(); settle();
    chk("R3 held", status_o[2], 1);
    chk("R3 vec", vec_o, 2);
    wr(3'd0, 32'h4);
    chk("R3 cleared", status_o[2], 0);
    @(negedge clk); ext_i[2] = 1; settle();
    chk("R3 set on rise", status_o[2], 1);
    wr(3'd0, 32'h4);
    settle(); settle();
    chk("R3 held high no reset", status_o[2], 0);
    quiet(); wr(3'd2, 0);
  endtask

  task automatic t_mask();
    wr(3'd1, 32'h1 << 16);
    @(negedge clk); rtc_i[0] = 1; #1;
    chk("R4 raw shows", status_o[16], 1);
    chk("R4 no irq", {irq_crit_o, irq_smi_o, irq_std_o}, 0);
    chk("R4 no vec", vec_o, 31);
    quiet(); wr(3'd1, 0);
  endtask

  task automatic t_per();
    wr(3'd4, 0);
    @(negedge clk); per_i[5] = 1; #1;
    chk("R5 LO", status_o[5:4], 2'b10);
    wr(3'd4, 32'h20);
    chk("R5 HI", status_o[5:4], 2'b01);
    wr(3'd4, 0);
    @(negedge clk); per_i = 19'h1; #1;
    chk("R6 DMA forced HI", status_o[5:4], 2'b01);
    chk("R6 vec", vec_o, 4);
    quiet();
  endtask

  task automatic t_wake();
    @(negedge clk); wake_i = 8'h40; #1;
    chk("R7 wake or", status_o[18], 1);
    chk("R7 vec", vec_o, 18);
    @(negedge clk); wake_i = 0; #1;
    chk("R7 wake idle", status_o[18], 0);
  endtask

  task automatic t_route();
    wr(3'd3, 32'h2 | (32'h1 << 6) | (32'h3 << 12));
    @(negedge clk); ext_i[0] = 1; #1;
    chk("R9 ext crit", {irq_crit_o, irq_smi_o, irq_std_o}, 3'b100);
    @(negedge clk); ext_i = 0; gpt_i[1] = 1; #1;
    chk("R9 gpt smi", {irq_crit_o, irq_smi_o, irq_std_o}, 3'b010);
    @(negedge clk); gpt_i = 0; gpio_i[2] = 1; #1;
    chk("R9 gpio std", {irq_crit_o, irq_smi_o, irq_std_o}, 3'b001);
    quiet(); wr(3'd3, 0);
  endtask

  task automatic t_vec();
    logic [31:0] d;
    @(negedge clk); gpio_i[3] = 1; slt_i[1] = 1;
    rd(3'd5, d);
    chk("R10 lowest index", vec_o, 7);
    chk("R10 reg", d, 7);
    quiet();
    rd(3'd5, d);
    chk("R10 none reg", d, 32'hFFFF_FFFF);
    chk("R10 none port", vec_o, 31);
  endtask

  task automatic t_lowpwr();
    @(negedge clk); lowpwr_i = 1; gpio_i[0] = 1; gpt_i[2] = 1; #1;
    chk("R8 raw gpio", status_o[19], 1);
    chk("R8 blocked", {irq_crit_o, irq_smi_o, irq_std_o}, 0);
    chk("R8 vec blocked", vec_o, 31);
    @(negedge clk); gpt_i[6] = 1; #1;
    chk("R8 gpt6 passes", vec_o, 14);
    chk("R8 gpt6 irq", irq_std_o, 1);
    @(negedge clk); gpt_i[6] = 0; wake_i[0] = 1; #1;
    chk("R8 wake passes", vec_o, 18);
    quiet();
  endtask

  task automatic t_wdt();
    @(negedge clk); wdt_i = 1; #1;
    chk("R11 not yet", srst_o, 0);
    settle();
    chk("R11 srst", srst_o, 1);
    chk("R11 no status", status_o, 0);
    chk("R11 no vec", vec_o, 31);
    quiet(); settle();
    chk("R11 srst off", srst_o, 0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_level(); t_edge(); t_mask(); t_per();
    t_wake(); t_route(); t_vec(); t_lowpwr(); t_wdt();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule